// File: doc/BRIEF.md
# DRAM Start-up and Refresh Sequencer

This block takes charge of an asynchronous DRAM from reset until the end of operation, as far as keeping its contents alive is concerned. After reset it keeps both strobes inactive for a programmable start-up delay. It then runs a fixed number of back-to-back CAS-before-RAS warm-up cycles and raises a ready flag. From then on it schedules one CAS-before-RAS refresh per refresh interval. Because the device advances its own internal row counter, no row address is ever driven. The default interval is 1950 clocks, which is 15.6 us at 125 MHz, so 1024 refreshes fit inside a 16 ms retention period.

The sequencer also arbitrates the shared DRAM bus against the access controller. The controller raises `acc_req` and may drive the bus only while `acc_gnt` is high. A refresh that falls due while the controller holds the bus is deferred and counted in a backlog. When the backlog reaches its limit, the grant is withdrawn and the refresh is forced. Once the controller lets go, all postponed refreshes run back to back. `drv_en` marks the cycles in which this block owns the strobes. `ras_n` and `cas_n` are meant to be multiplexed onto the pins under `drv_en`.

Top module: `dram_rfsh_ctl`

## Requirements
- R1: While reset is asserted, `ras_n` and `cas_n` are 1 and `drv_en`, `ready` and `acc_gnt` are 0.
- R2: After reset is released, `drv_en` first reads 1 exactly STARTUP_CYC clock cycles later, and the strobes stay inactive until then.
- R3: Exactly INIT_CYC CAS-before-RAS cycles are issued before `ready` rises, and `ready` never falls again until the next reset.
- R4: `acc_gnt` stays 0 while `ready` is 0, whatever `acc_req` does.
- R5: In every refresh cycle `cas_n` falls while `ras_n` is 1 and stays low for exactly CSR_CYC cycles before `ras_n` falls.
- R6: `ras_n` stays low for exactly RAS_CYC cycles, and `cas_n` stays low for exactly CHR_CYC of those cycles, counted from the fall of `ras_n`.
- R7: After `ras_n` rises, both strobes are held high with `drv_en` = 1 for exactly RP_CYC cycles, before the next fall of `cas_n` or the release of the bus.
- R8: With `acc_req` low and the device ready, successive falls of `ras_n` are exactly REF_INTERVAL_CYC cycles apart.
- R9: While `acc_req` is high and fewer than MAX_PEND refreshes are owed, `acc_gnt` stays 1 and no refresh is started.
- R10: When the backlog reaches MAX_PEND while the bus is not in a refresh, `acc_gnt` drops in that same cycle and `drv_en` is 1 in the next cycle. The backlog never exceeds MAX_PEND.
- R11: After `acc_req` falls, the remaining backlog is worked off with one refresh per owed interval. Successive `ras_n` falls are CSR_CYC+RAS_CYC+RP_CYC+1 cycles apart.
- R12: `acc_gnt` and `drv_en` are never high together, and `ras_n` and `cas_n` are 1 whenever `drv_en` is 0.
- R13: When the block is ready, idle and owes no refresh, `acc_gnt` follows `acc_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access controller asks for the DRAM bus |
| acc_gnt | output | 1 | Access controller may drive the bus this cycle |
| ready | output | 1 | Start-up delay and warm-up cycles are complete |
| drv_en | output | 1 | Sequencer owns the strobes this cycle |
| ras_n | output | 1 | Row strobe from the sequencer, active low |
| cas_n | output | 1 | Column strobe from the sequencer, active low |

## Verification
The checker relies on the access controller giving up the bus as soon as `acc_gnt` drops, even while `acc_req` is still high. It also relies on CHR_CYC being smaller than RAS_CYC and on every phase length being at least one clock. The bench changes `acc_req` only just after a falling clock edge. It raises `acc_req` only once a refresh has ended, and it drops `acc_req` as soon as the forced refresh has finished. The drain of the backlog therefore completes well before the next interval falls due. The bench parameters keep one refresh cycle far shorter than the interval, so a tick is never lost behind a running refresh.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  // Sequencer phases: start-up wait, bus idle, CAS setup, RAS low, precharge
  typedef enum logic [2:0] {
    SQ_WAIT = 3'd0,
    SQ_IDLE = 3'd1,
    SQ_CSET = 3'd2,
    SQ_RLOW = 3'd3,
    SQ_PRCH = 3'd4
  } sq_state_e;

endpackage

// File: rtl/dram_rfsh_tick.sv
// Interval timer: one tick every INTERVAL_CYC clocks while enabled.
module dram_rfsh_tick #(
  parameter int INTERVAL_CYC = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [W-1:0] LOAD = W'(INTERVAL_CYC - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == '0);
    cnt_d = cnt_q;
    if (!en || tick) cnt_d = LOAD;
    else             cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LOAD;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dram_rfsh_backlog.sv
// Saturating count of refreshes owed.
module dram_rfsh_backlog #(
  parameter int MAX_PEND = 8,
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          take,
  output logic [PW-1:0] pend,
  output logic          pend_nz,
  output logic          pend_full
);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PEND);

  logic [PW-1:0] pend_q, pend_d;
  logic          upd_en;

  always_comb begin
    upd_en = tick ^ take;
    pend_d = pend_q;
    if (tick && !take && pend_q != PMAX) pend_d = pend_q + PW'(1);
    else if (take && !tick)              pend_d = pend_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_d;
  end

  assign pend      = pend_q;
  assign pend_nz   = (pend_q != '0);
  assign pend_full = (pend_q == PMAX);
endmodule

// File: rtl/dram_rfsh_seq.sv
// Phase sequencer: start-up wait, warm-up cycles, CAS-before-RAS cycles, bus arbitration.
module dram_rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int STARTUP_CYC = 25000,
  parameter int INIT_CYC    = 8,
  parameter int CSR_CYC     = 2,
  parameter int CHR_CYC     = 2,
  parameter int RAS_CYC     = 8,
  parameter int RP_CYC      = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic pend_nz,
  input  logic pend_full,
  output logic take,
  output logic acc_gnt,
  output logic ready,
  output logic drv_en,
  output logic ras_n,
  output logic cas_n
);
  localparam int M1 = (STARTUP_CYC > RAS_CYC) ? STARTUP_CYC : RAS_CYC;
  localparam int M2 = (M1 > CSR_CYC) ? M1 : CSR_CYC;
  localparam int M3 = (M2 > RP_CYC) ? M2 : RP_CYC;
  localparam int TW = $clog2(M3 + 1);
  localparam int IW = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;

  localparam logic [TW-1:0] L_START = TW'(STARTUP_CYC - 1);
  localparam logic [TW-1:0] L_CSR   = TW'(CSR_CYC - 1);
  localparam logic [TW-1:0] L_RAS   = TW'(RAS_CYC - 1);
  localparam logic [TW-1:0] L_RP    = TW'(RP_CYC - 1);
  localparam logic [TW-1:0] CHR_LO  = TW'(RAS_CYC - CHR_CYC);
  localparam logic [IW-1:0] I_LAST  = IW'(INIT_CYC - 1);

  sq_state_e     state_q, state_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] init_q, init_d;
  logic          ready_q, ready_d;
  logic          done;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    init_d  = init_q;
    ready_d = ready_q;
    done    = (cnt_q == '0);
    take    = (state_q == SQ_IDLE) && pend_nz && (!acc_req || pend_full);
    case (state_q)
      SQ_WAIT: begin
        if (done) begin state_d = SQ_CSET; cnt_d = L_CSR; end
        else      cnt_d = cnt_q - TW'(1);
      end
      SQ_IDLE: begin
        if (take) begin state_d = SQ_CSET; cnt_d = L_CSR; end
      end
      SQ_CSET: begin
        if (done) begin state_d = SQ_RLOW; cnt_d = L_RAS; end
        else      cnt_d = cnt_q - TW'(1);
      end
      SQ_RLOW: begin
        if (done) begin state_d = SQ_PRCH; cnt_d = L_RP; end
        else      cnt_d = cnt_q - TW'(1);
      end
      SQ_PRCH: begin
        if (!done) begin
          cnt_d = cnt_q - TW'(1);
        end else if (ready_q) begin
          state_d = SQ_IDLE;
        end else if (init_q == I_LAST) begin
          ready_d = 1'b1;
          state_d = SQ_IDLE;
        end else begin
          init_d  = init_q + IW'(1);
          state_d = SQ_CSET;
          cnt_d   = L_CSR;
        end
      end
      default: state_d = SQ_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_WAIT;
      cnt_q   <= L_START;
      init_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      init_q  <= init_d;
      ready_q <= ready_d;
    end
  end

  assign ready   = ready_q;
  assign drv_en  = (state_q == SQ_CSET) || (state_q == SQ_RLOW) || (state_q == SQ_PRCH);
  assign ras_n   = (state_q != SQ_RLOW);
  assign cas_n   = !((state_q == SQ_CSET) || ((state_q == SQ_RLOW) && (cnt_q >= CHR_LO)));
  assign acc_gnt = (state_q == SQ_IDLE) && acc_req && !take;
endmodule

// File: rtl/dram_rfsh_ctl.sv
// Top: DRAM start-up and refresh sequencer with bus arbitration.
module dram_rfsh_ctl #(
  parameter int STARTUP_CYC      = 25000,
  parameter int INIT_CYC         = 8,
  parameter int REF_INTERVAL_CYC = 1950,
  parameter int MAX_PEND         = 8,
  parameter int CSR_CYC          = 2,
  parameter int CHR_CYC          = 2,
  parameter int RAS_CYC          = 8,
  parameter int RP_CYC           = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  output logic acc_gnt,
  output logic ready,
  output logic drv_en,
  output logic ras_n,
  output logic cas_n
);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic          tick;
  logic          take;
  logic          pend_nz;
  logic          pend_full;
  logic [PW-1:0] pend_cnt;

  dram_rfsh_tick #(
    .INTERVAL_CYC(REF_INTERVAL_CYC)
  ) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ready),
    .tick (tick)
  );

  dram_rfsh_backlog #(
    .MAX_PEND(MAX_PEND)
  ) u_backlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .take     (take),
    .pend     (pend_cnt),
    .pend_nz  (pend_nz),
    .pend_full(pend_full)
  );

  dram_rfsh_seq #(
    .STARTUP_CYC(STARTUP_CYC),
    .INIT_CYC   (INIT_CYC),
    .CSR_CYC    (CSR_CYC),
    .CHR_CYC    (CHR_CYC),
    .RAS_CYC    (RAS_CYC),
    .RP_CYC     (RP_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_req  (acc_req),
    .pend_nz  (pend_nz),
    .pend_full(pend_full),
    .take     (take),
    .acc_gnt  (acc_gnt),
    .ready    (ready),
    .drv_en   (drv_en),
    .ras_n    (ras_n),
    .cas_n    (cas_n)
  );
endmodule

// File: rtl/dram_rfsh_chk.sv
// Protocol checker bound to the sequencer top.
module dram_rfsh_chk #(
  parameter int MAX_PEND = 8,
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_req,
  input logic          acc_gnt,
  input logic          ready,
  input logic          drv_en,
  input logic          ras_n,
  input logic          cas_n,
  input logic [PW-1:0] pend_cnt,
  input logic          pend_full
);
  AST_NO_EARLY_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !acc_gnt); // R4
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R3
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n); // R5
  AST_CAS_FALLS_RAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ras_n); // R5
  AST_BACKLOG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_cnt) <= MAX_PEND); // R10
  AST_FORCED_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_full && ready && !drv_en) |=> drv_en); // R10
  AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_gnt && drv_en)); // R12
  AST_QUIET_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (ras_n && cas_n)); // R12
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> acc_req); // R13
endmodule

bind dram_rfsh_ctl dram_rfsh_chk #(.MAX_PEND(MAX_PEND)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_req  (acc_req),
  .acc_gnt  (acc_gnt),
  .ready    (ready),
  .drv_en   (drv_en),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .pend_cnt (pend_cnt),
  .pend_full(pend_full)
);

// File: tb/dram_rfsh_ctl_tb.sv
`timescale 1ns/1ps
module dram_rfsh_ctl_tb;
  localparam int STARTUP  = 50;
  localparam int INIT     = 8;
  localparam int INTERVAL = 200;
  localparam int MAXP     = 8;
  localparam int CSR      = 2;
  localparam int CHR      = 2;
  localparam int RASC     = 4;
  localparam int RP       = 3;

  logic clk;
  logic rst_n;
  logic acc_req;
  logic acc_gnt, ready, drv_en, ras_n, cas_n;

  int total = 0;
  int bad   = 0;

  dram_rfsh_ctl #(
    .STARTUP_CYC(STARTUP), .INIT_CYC(INIT), .REF_INTERVAL_CYC(INTERVAL),
    .MAX_PEND(MAXP), .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASC), .RP_CYC(RP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_gnt(acc_gnt),
    .ready(ready), .drv_en(drv_en), .ras_n(ras_n), .cas_n(cas_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Strobe monitor: measures every phase of every refresh cycle
  int cyc = 0, nfall = 0, last_fall = 0, last_gap = 0;
  int csr_n = 0, chr_n = 0, ras_len = 0, pre_n = 0;
  int excl_bad = 0, ready_drop = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_drv = 1'b0, p_rdy = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1'b1; p_cas = 1'b1; p_drv = 1'b0; p_rdy = 1'b0;
      csr_n = 0; pre_n = 0;
    end else begin
      cyc++;
      if (acc_gnt && drv_en) excl_bad++;
      if (!drv_en && (!ras_n || !cas_n)) excl_bad++;
      if (p_rdy && !ready) ready_drop++;
      if (p_cas && !cas_n) begin
        if (pre_n > 0) chk(pre_n == RP, "R7 precharge before next cycle", pre_n, RP);
        chk(ras_n == 1'b1, "R5 cas falls with ras high", int'(ras_n), 1);
        pre_n = 0;
        csr_n = 0;
      end
      if (drv_en && !cas_n && ras_n) csr_n++;
      if (p_ras && !ras_n) begin
        chk(csr_n == CSR, "R5 cas setup length", csr_n, CSR);
        last_gap  = cyc - last_fall;
        last_fall = cyc;
        nfall++;
        chr_n   = 0;
        ras_len = 0;
      end
      if (!ras_n) ras_len++;
      if (!ras_n && !cas_n) chr_n++;
      if (!p_ras && ras_n) begin
        chk(ras_len == RASC, "R6 ras low length", ras_len, RASC);
        chk(chr_n == CHR, "R6 cas hold after ras", chr_n, CHR);
        pre_n = 0;
      end
      if (drv_en && ras_n && cas_n) pre_n++;
      if (p_drv && !drv_en) begin
        chk(pre_n == RP, "R7 precharge before release", pre_n, RP);
        pre_n = 0;
      end
      p_ras = ras_n; p_cas = cas_n; p_drv = drv_en; p_rdy = ready;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  task automatic t_reset_and_startup();
    int n;
    rst_n   = 1'b0;
    acc_req = 1'b1;
    repeat (3) step();
    chk(ras_n == 1'b1 && cas_n == 1'b1, "R1 strobes high in reset", {ras_n, cas_n}, 3);
    chk(drv_en == 1'b0 && ready == 1'b0, "R1 drv_en/ready low in reset", {drv_en, ready}, 0);
    chk(acc_gnt == 1'b0, "R1 no grant in reset", int'(acc_gnt), 0);
    rst_n = 1'b1;
    n = 0;
    do begin
      step();
      n++;
    end while (!drv_en && n < 1000);
    chk(n == STARTUP, "R2 start-up delay", n, STARTUP);
  endtask

  task automatic t_init();
    int  n = 0;
    bit  gnt_seen = 1'b0;
    while (!ready && n < 1000) begin
      if (acc_gnt) gnt_seen = 1'b1;
      step();
      n++;
    end
    chk(nfall == INIT, "R3 warm-up cycles before ready", nfall, INIT);
    chk(!gnt_seen, "R4 no grant before ready", int'(gnt_seen), 0);
    chk(acc_gnt == 1'b1, "R13 grant follows request", int'(acc_gnt), 1);
    acc_req = 1'b0;
    #1;
    chk(acc_gnt == 1'b0, "R13 grant drops with request", int'(acc_gnt), 0);
  endtask

  task automatic t_interval();
    int seen = nfall;
    int done = 0;
    int n = 0;
    while (done < 3 && n < 2000) begin
      step();
      n++;
      if (nfall != seen) begin
        seen = nfall;
        if (nfall > INIT + 1) begin
          chk(last_gap == INTERVAL, "R8 refresh spacing", last_gap, INTERVAL);
          done++;
        end
      end
    end
    chk(done == 3, "R8 periodic refreshes seen", done, 3);
  endtask

  task automatic t_defer_force_drain();
    int n = 0;
    int f0;
    int seen;
    int g = 0;
    while (!drv_en && g < 1000) begin step(); g++; end
    while (drv_en && g < 2000) begin step(); g++; end
    acc_req = 1'b1;
    #1;
    chk(acc_gnt == 1'b1, "R13 grant with empty backlog", int'(acc_gnt), 1);
    f0 = nfall;
    while (n < 5000) begin
      step();
      if (!acc_gnt) break;
      n++;
    end
    chk(nfall == f0 && !drv_en, "R9 no refresh while deferred", nfall - f0, 0);
    chk(n >= 7 * INTERVAL && n <= 8 * INTERVAL, "R9 deferral length", n, 8 * INTERVAL);
    step();
    chk(drv_en == 1'b1, "R10 forced refresh starts", int'(drv_en), 1);
    chk(acc_gnt == 1'b0, "R10 grant withdrawn", int'(acc_gnt), 0);
    g = 0;
    while (drv_en && g < 100) begin step(); g++; end
    chk(acc_gnt == 1'b1, "R9 grant resumes below limit", int'(acc_gnt), 1);
    acc_req = 1'b0;
    f0   = nfall;
    seen = nfall;
    for (int i = 0; i < 120; i++) begin
      step();
      if (nfall != seen) begin
        seen = nfall;
        if (nfall - f0 >= 2)
          chk(last_gap == CSR + RASC + RP + 1, "R11 drain spacing", last_gap, CSR + RASC + RP + 1);
      end
    end
    chk(nfall - f0 == MAXP - 1, "R11 drained refreshes", nfall - f0, MAXP - 1);
  endtask

  task automatic t_final();
    chk(excl_bad == 0, "R12 bus exclusivity", excl_bad, 0);
    chk(ready_drop == 0, "R3 ready stays high", ready_drop, 0);
  endtask

  initial begin
    t_reset_and_startup();
    t_init();
    t_interval();
    t_defer_force_drain();
    t_final();
    finish_run();
  end
endmodule